// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block is a bank of independent down-counters. A processor reaches it through a small register bus, and each counter can raise an interrupt. Each channel holds a 32-bit count and an interval register. It advances on its own tick, which is built from one of four tick-source pulse inputs followed by a power-of-two prescaler. In periodic mode a channel refills itself from the interval every time it runs out. In single-shot mode it stops at zero and drops its enable bit. If software loads an all-ones interval in periodic mode, the channel becomes a free-running 32-bit down-counter that can serve as a time base.

Software starts a channel in three steps: it writes the interval, sets the reload bit so the interval is copied in on the next channel tick, and sets the enable bit. Enable changes are not immediate. The new value takes effect only on the second channel tick after the write, so software can treat the enable as settled once the free-running channel has moved by a few counts. On every expiry the channel sets a sticky per-channel status bit, which software clears by writing one to it. The single interrupt line is active while any channel has both its status bit and its interrupt-enable bit set.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Address map. 0x00 is the interrupt-enable register (bit n for channel n). 0x04 is the status register. Channel n uses 0x10+0x10*n for control, 0x14+0x10*n for interval and 0x18+0x10*n for the current count. Control bits are: bit 0 enable, bit 1 reload, bits 3:2 tick-source select, bits 6:4 prescaler exponent, bit 7 single-shot. Any other offset (including any offset ending in 0xC, or a channel block past the last channel) reads zero and ignores writes. The count register ignores writes.
- R3: A one written to the reload bit copies the interval into the count on the next channel tick, whether or not the channel is enabled. The bit then clears itself and reads back as zero.
- R4: A change of the enable bit takes effect on the second channel tick after the write. While effectively enabled, the count drops by one per channel tick. Once effectively disabled, it holds.
- R5: Periodic mode (bit 7 = 0). The tick that takes the count to zero is followed by a tick that reloads the interval, so the period is interval+1 ticks. An all-ones interval gives a free-running 32-bit down-count.
- R6: Single-shot mode (bit 7 = 1). On the tick that takes the count to zero the channel stops: the enable bit reads zero and the count stays zero.
- R7: The channel tick is every 2^p-th pulse of `tick_src[s]`, where p is the prescaler field and s is the source field. A write to a channel's control register restarts that channel's prescaler, so with p=2 and a source pulsing every cycle the first channel tick falls 4 cycles after the write edge.
- R8: A channel's status bit is set on the same clock edge that its count becomes zero. Writing 1 to a status bit clears it, and writing 0 has no effect. A new expiry wins over a clear in the same cycle.
- R9: `irq` is high exactly when some channel has both its status bit and its interrupt-enable bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_src | input | 4 | Tick-source pulses, one cycle wide, selected per channel |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Shared interrupt request |

## Verification
A stuck or wrongly advanced prescaler or enable synchroniser shows up on the first read of the count register, because the count leaves its expected value one channel tick after the fault. This is the basis for checking counts at exact cycle offsets after each control write. A status bit that is lost or wrongly set appears on `irq` in the same cycle once its enable bit is set, and it stays visible in the status register because the bit is sticky. A single-shot channel that fails to stop shows up as a nonzero count or a set enable bit a few ticks after the expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int SRC_W      = 2;
    localparam int NSRC       = 1 << SRC_W;
    localparam int PRE_W      = 3;
    localparam int SYNC_TICKS = 2;

    localparam logic [3:0] OFS_IEN  = 4'h0;
    localparam logic [3:0] OFS_STAT = 4'h4;
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_INTV = 4'h4;
    localparam logic [3:0] OFS_CNT  = 4'h8;

    typedef struct packed {
        logic             single;
        logic [PRE_W-1:0] presc;
        logic [SRC_W-1:0] src;
        logic             reload;
        logic             en;
    } ctrl_t;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_IEN,
        RG_STAT,
        RG_CTRL,
        RG_INTV,
        RG_CNT
    } reg_kind_e;

    function automatic reg_kind_e decode_kind(input logic global_blk,
                                              input logic [3:0] sub);
        reg_kind_e k;
        k = RG_NONE;
        if (global_blk) begin
            if (sub == OFS_IEN)       k = RG_IEN;
            else if (sub == OFS_STAT) k = RG_STAT;
        end else begin
            if (sub == OFS_CTRL)      k = RG_CTRL;
            else if (sub == OFS_INTV) k = RG_INTV;
            else if (sub == OFS_CNT)  k = RG_CNT;
        end
        return k;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          src_tick,
    input  logic [PW-1:0] exp_sel,
    output logic          tick_out
);
    localparam int LIM_W = (1 << PW) - 1;
    localparam logic [LIM_W-1:0] ONES = {LIM_W{1'b1}};

    logic [LIM_W-1:0] pcnt;
    logic [LIM_W-1:0] lim;

    always_comb begin
        lim = ONES >> (LIM_W - int'(exp_sel));
    end

    assign tick_out = src_tick && (pcnt == lim);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt <= '0;
        end else if (src_tick) begin
            if (pcnt == lim) pcnt <= '0;
            else             pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_enable_sync.sv
module tmr_enable_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic en_req,
    input  logic force_off,
    output logic en_eff
);
    localparam int SW = $clog2(SYNC + 1);

    logic [SW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || force_off) begin
            en_eff   <= 1'b0;
            wait_cnt <= '0;
        end else if (en_req == en_eff) begin
            wait_cnt <= '0;
        end else if (tick) begin
            if (wait_cnt == SW'(SYNC - 1)) begin
                en_eff   <= en_req;
                wait_cnt <= '0;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_ticks,
    input  logic             ctrl_we,
    input  ctrl_t            ctrl_wd,
    input  logic             intv_we,
    input  logic [CNT_W-1:0] intv_wd,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] intv_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] intv_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ch_tick;
    logic             en_eff;
    logic             stop;

    tmr_prescaler #(.PW(PRE_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (ctrl_we),
        .src_tick (src_ticks[ctrl_q.src]),
        .exp_sel  (ctrl_q.presc),
        .tick_out (ch_tick)
    );

    tmr_enable_sync #(.SYNC(SYNC_TICKS)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .tick      (ch_tick),
        .en_req    (ctrl_q.en),
        .force_off (stop),
        .en_eff    (en_eff)
    );

    assign expire = ch_tick && !ctrl_q.reload && en_eff
                    && (cnt_q == CNT_W'(1));
    assign stop   = expire && ctrl_q.single;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            intv_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (ch_tick) begin
                if (ctrl_q.reload) begin
                    cnt_q         <= intv_q;
                    ctrl_q.reload <= 1'b0;
                end else if (en_eff) begin
                    if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
                    else if (!ctrl_q.single) cnt_q <= intv_q;
                end
            end
            if (stop)    ctrl_q.en <= 1'b0;
            if (ctrl_we) ctrl_q    <= ctrl_wd;
            if (intv_we) intv_q    <= intv_wd;
        end
    end

    assign ctrl_o = ctrl_q;
    assign intv_o = intv_q;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import tmr_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   tick_src,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 4;

    logic [IDX_W-1:0] blk;
    logic [3:0]       sub;
    reg_kind_e        kind;
    logic [NCH-1:0]   ch_hit;

    logic [NCH-1:0]   irq_en_q;
    logic [NCH-1:0]   status_q;
    logic [NCH-1:0]   expire;
    logic [NCH-1:0]   clr_mask;

    ctrl_t            ctrl_arr [NCH];
    logic [CNT_W-1:0] intv_arr [NCH];
    logic [CNT_W-1:0] cnt_arr  [NCH];

    assign blk  = bus_addr[ADDR_W-1:4];
    assign sub  = bus_addr[3:0];
    assign kind = decode_kind(blk == '0, sub);

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            assign ch_hit[g] = (blk == IDX_W'(g + 1));

            tmr_channel #(.CNT_W(CNT_W)) u_ch (
                .clk       (clk),
                .rst       (rst),
                .src_ticks (tick_src),
                .ctrl_we   (bus_wr && ch_hit[g] && kind == RG_CTRL),
                .ctrl_wd   (ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0])),
                .intv_we   (bus_wr && ch_hit[g] && kind == RG_INTV),
                .intv_wd   (bus_wdata[CNT_W-1:0]),
                .ctrl_o    (ctrl_arr[g]),
                .intv_o    (intv_arr[g]),
                .cnt_o     (cnt_arr[g]),
                .expire    (expire[g])
            );
        end
    endgenerate

    assign clr_mask = (bus_wr && kind == RG_STAT) ? bus_wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en_q <= '0;
            status_q <= '0;
        end else begin
            if (bus_wr && kind == RG_IEN) irq_en_q <= bus_wdata[NCH-1:0];
            status_q <= expire | (status_q & ~clr_mask);
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (kind)
            RG_IEN:  bus_rdata = DATA_W'(irq_en_q);
            RG_STAT: bus_rdata = DATA_W'(status_q);
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (ch_hit[i]) begin
                        if (kind == RG_CTRL)      bus_rdata = DATA_W'(ctrl_arr[i]);
                        else if (kind == RG_INTV) bus_rdata = DATA_W'(intv_arr[i]);
                        else if (kind == RG_CNT)  bus_rdata = DATA_W'(cnt_arr[i]);
                    end
                end
            end
        endcase
    end

    assign irq = |(status_q & irq_en_q);

endmodule

// File: rtl/tmr_bank_checker.sv
module tmr_bank_checker
    import tmr_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic [NCH-1:0]    irq_en_q,
    input logic [NCH-1:0]    status_q,
    input logic [NCH-1:0]    expire,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata
);
    // R9: no interrupt while every enable bit is clear
    a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (rst)
        (irq_en_q == '0) |-> !irq);

    // R9: no interrupt while nothing is pending
    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        (status_q == '0) |-> !irq);

    // R2: offsets ending in 0xC are holes
    a_r2_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[3:0] == 4'hC) |-> (bus_rdata == '0));

    // R2: channel blocks past the last channel are holes
    a_r2_missing_channel_zero: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr[ADDR_W-1:4]) > NCH) |-> (bus_rdata == '0));

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_st
            // R8: expiry leaves the status bit set
            a_r8_expiry_sets: assert property (@(posedge clk) disable iff (rst)
                expire[g] |=> status_q[g]);

            // R8: write-one clears when no expiry competes
            a_r8_w1c_clears: assert property (@(posedge clk) disable iff (rst)
                (bus_wr && bus_addr == 8'h04 && bus_wdata[g] && !expire[g])
                |=> !status_q[g]);

            // R8: status is sticky without a clearing write
            a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
                (status_q[g] && !(bus_wr && bus_addr == 8'h04 && bus_wdata[g]))
                |=> status_q[g]);
        end
    endgenerate

endmodule

bind tick_timer_bank tmr_bank_checker #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .irq_en_q  (irq_en_q),
    .status_q  (status_q),
    .expire    (expire),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
);

// File: tb/tick_timer_bank_test.sv
`timescale 1ns/1ps
module tick_timer_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  tick_src = 4'b0001;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2 clk = ~clk;

    tick_timer_bank uut (
        .clk       (clk),
        .rst       (rst),
        .tick_src  (tick_src),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int n_chk = 0;
    int n_bad = 0;
    int nidx  = 0;
    int base  = 0;
    bit done  = 0;

    // monitor: pops one expected item and compares before the next edge
    initial begin
        item_t it;
        logic [31:0] act;
        forever begin
            wait (sb_q.size() > 0);
            #1;
            it  = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        nidx++;
    endtask

    task automatic goto_k(input int k);
        while (nidx < base + k) step();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step();
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        step();
        bus_wr    = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        step();
        bus_addr  = a;
        it.is_irq = 1'b0;
        it.exp    = e;
        it.tag    = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        step();
        it.is_irq = 1'b1;
        it.exp    = {31'b0, e};
        it.tag    = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    // periodic interval 100, k negedges after the enabling write
    function automatic logic [31:0] per_cnt(input int k);
        if (k < 3)        return 32'd100;
        else if (k <= 102) return 32'(102 - k);
        else               return 32'(100 - ((k - 103) % 101));
    endfunction

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int jd;
        logic [31:0] frozen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_rd(8'h00, 32'h0, "R1 ien reset");
        chk_rd(8'h04, 32'h0, "R1 status reset");
        chk_rd(8'h10, 32'h0, "R1 ctrl0 reset");
        chk_rd(8'h14, 32'h0, "R1 intv0 reset");
        chk_rd(8'h28, 32'h0, "R1 cnt1 reset");
        chk_irq(1'b0, "R1 irq reset");

        // R2 holes and missing channel
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h08, 32'h0000_0005);
        wr(8'h30, 32'h0000_00FF);
        chk_rd(8'h0C, 32'h0, "R2 hole 0x0C");
        chk_rd(8'h08, 32'h0, "R2 hole 0x08");
        chk_rd(8'h30, 32'h0, "R2 missing channel ctrl");
        chk_rd(8'h10, 32'h0, "R2 ctrl0 untouched by hole writes");
        chk_rd(8'h20, 32'h0, "R2 ctrl1 untouched by hole writes");

        // R3 reload while disabled
        wr(8'h14, 32'd100);
        wr(8'h10, 32'h02);
        base = nidx;
        chk_rd(8'h18, 32'd100, "R3 reload copies interval");
        chk_rd(8'h10, 32'h00, "R3 reload bit self clears");
        chk_rd(8'h18, 32'd100, "R4 disabled count holds");
        chk_rd(8'h14, 32'd100, "R2 interval readback");

        // R4/R5 enable, periodic
        wr(8'h10, 32'h01);
        base = nidx;
        chk_rd(8'h18, per_cnt(1), "R4 no count at tick 1");
        chk_rd(8'h18, per_cnt(2), "R4 no count at tick 2");
        chk_rd(8'h18, per_cnt(3), "R4 first decrement");
        chk_rd(8'h18, per_cnt(4), "R4 steady decrement");
        goto_k(100);
        chk_rd(8'h18, 32'd1, "R5 count before expiry");
        chk_rd(8'h04, 32'h1, "R8 status set on zero");
        chk_rd(8'h18, 32'd100, "R5 periodic reload");
        chk_irq(1'b0, "R9 masked irq");
        wr(8'h00, 32'h1);
        chk_irq(1'b1, "R9 irq enabled");
        wr(8'h04, 32'h0);
        chk_rd(8'h04, 32'h1, "R8 write zero no effect");
        wr(8'h04, 32'h1);
        chk_rd(8'h04, 32'h0, "R8 write one clears");
        chk_irq(1'b0, "R9 irq drops after clear");

        // R4 disable delay
        jd = nidx - base;
        wr(8'h10, 32'h00);
        frozen = per_cnt(jd + 4);
        chk_rd(8'h18, per_cnt(jd + 3), "R4 still counting after disable");
        chk_rd(8'h18, frozen, "R4 last decrement");
        goto_k(jd + 10);
        chk_rd(8'h18, frozen, "R4 disabled count frozen");

        // R6/R7 single shot with divide by 4
        wr(8'h24, 32'd3);
        wr(8'h20, 32'hA3);
        base = nidx;
        goto_k(2);
        chk_rd(8'h28, 32'd0, "R7 no tick before 4 pulses");
        chk_rd(8'h28, 32'd3, "R7 first prescaled tick reloads");
        goto_k(10);
        chk_rd(8'h28, 32'd3, "R7 no decrement before tick 3");
        chk_rd(8'h28, 32'd2, "R7 decrement every 4 cycles");
        goto_k(20);
        chk_rd(8'h28, 32'd0, "R6 reaches zero");
        chk_rd(8'h04, 32'h2, "R8 status ch1");
        chk_rd(8'h20, 32'hA0, "R6 enable cleared on stop");
        chk_irq(1'b0, "R9 ch1 masked");
        goto_k(40);
        chk_rd(8'h28, 32'd0, "R6 count stays zero");
        wr(8'h00, 32'h3);
        chk_irq(1'b1, "R9 ch1 enabled");
        wr(8'h04, 32'h2);
        chk_rd(8'h04, 32'h0, "R8 ch1 cleared");
        chk_irq(1'b0, "R9 ch1 irq low");

        // R5 free running all-ones, R2 count read-only
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h10, 32'h03);
        base = nidx;
        chk_rd(8'h18, 32'hFFFF_FFFF, "R5 all-ones loaded");
        goto_k(9);
        chk_rd(8'h18, 32'hFFFF_FFFF - 32'd8, "R5 free running");
        wr(8'h18, 32'h0000_1234);
        chk_rd(8'h18, 32'hFFFF_FFFF - 32'(nidx - base + 1 - 2), "R2 count read-only");

        done = 1'b1;
        finish_run();
    end

endmodule